// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block sits next to a shared two-port memory and produces one cross-port interrupt for each side, the left port and the right port. Each side owns a mailbox word at one of the two highest addresses of the memory: the left side owns the address one below the top, and the right side owns the top address. When the opposite side writes a message into a mailbox, the owner's interrupt goes active. When the owner reads its mailbox, the interrupt goes inactive. The message itself stays in the ordinary memory word. This block only watches the access controls of both ports and holds the two flags.

Both ports are sampled on one shared clock. A mailbox write from a port whose collision busy input is low is treated as blocked, and it does not raise the interrupt. The interrupt outputs are active low. They are registered, so they change on the clock edge that samples the access. An asynchronous active-low reset forces both outputs inactive. The reset is released through a synchronizer.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: While reset is active, and until the first qualifying set after reset, both `l_irq_n` and `r_irq_n` are high (inactive).
- R2: A right-port write (`r_en_n`=0, `r_we_n`=0, `r_busy_n`=1) to the left mailbox address (all ones minus one, 0xFFE for a 12-bit address) drives `l_irq_n` low on the clock edge that samples it.
- R3: A left-port access with `l_en_n`=0 and `l_oe_n`=0 at 0xFFE drives `l_irq_n` high on the sampling edge. `l_we_n` has no effect on this clear.
- R4: A left-port write (`l_en_n`=0, `l_we_n`=0, `l_busy_n`=1) to the right mailbox address (all ones, 0xFFF) drives `r_irq_n` low on the sampling edge.
- R5: A right-port access with `r_en_n`=0 and `r_oe_n`=0 at 0xFFF drives `r_irq_n` high on the sampling edge. `r_we_n` has no effect on this clear.
- R6: A mailbox write made while the writing port's busy input is low leaves the other side's interrupt unchanged.
- R7: If a set and a clear reach the same flag on the same edge, the flag ends up asserted (output low).
- R8: Each of the following leaves both flags unchanged:
  - accesses to any non-mailbox address;
  - accesses with enable high;
  - mailbox reads by the non-owning port;
  - an owner access with `oe_n` high.
- R9: The two flags are independent. Both can be set on the same edge, and clearing one leaves the other asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock sampling both ports |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| l_en_n | input | 1 | Left port enable, active low |
| l_oe_n | input | 1 | Left port output enable, active low |
| l_we_n | input | 1 | Left port write strobe, active low |
| l_addr | input | AW | Left port address |
| l_busy_n | input | 1 | Left port collision busy, low blocks its writes |
| l_irq_n | output | 1 | Left side interrupt, active low |
| r_en_n | input | 1 | Right port enable, active low |
| r_oe_n | input | 1 | Right port output enable, active low |
| r_we_n | input | 1 | Right port write strobe, active low |
| r_addr | input | AW | Right port address |
| r_busy_n | input | 1 | Right port collision busy, low blocks its writes |
| r_irq_n | output | 1 | Right side interrupt, active low |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- Same-edge set and clear. A design that lets the clear win would lose a message and leave the interrupt high.
- Blocked writes. A design that ignores busy would raise an interrupt for a write the memory discarded.
- The owner writing its own mailbox with `oe_n` low. This must still clear, and a design that required `we_n` high would keep the flag stuck.
- Swapped mailbox addresses, and reads by the wrong side. A design that got either wrong would set or clear the opposite flag. The reference model compares both outputs every clock, so this shows up as a mismatch on the untouched side.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int NPORT = 2;
  localparam int LEFT  = 0;
  localparam int RIGHT = 1;

  typedef struct packed {
    logic en_n;
    logic oe_n;
    logic we_n;
    logic busy_n;
  } port_ctl_t;
endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int MSB = STAGES - 1;

  logic [MSB:0] sync_q;
  logic [MSB:0] sync_d;

  always_comb begin
    sync_d = {sync_q[MSB-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[MSB];
endmodule

// File: rtl/mbox_port_decode.sv
module mbox_port_decode
  import mbox_pkg::*;
#(
  parameter int             AW        = 12,
  parameter logic [AW-1:0]  OWN_ADDR  = '1,
  parameter logic [AW-1:0]  PEER_ADDR = '1
) (
  input  port_ctl_t        ctl_i,
  input  logic [AW-1:0]    addr_i,
  output logic             wr_peer_o,
  output logic             rd_own_o
);
  logic sel;
  logic hit_own;
  logic hit_peer;

  always_comb begin
    sel       = !ctl_i.en_n;
    hit_own   = (addr_i == OWN_ADDR);
    hit_peer  = (addr_i == PEER_ADDR);
    wr_peer_o = sel && !ctl_i.we_n && hit_peer && ctl_i.busy_n;
    rd_own_o  = sel && !ctl_i.oe_n && hit_own;
  end
endmodule

// File: rtl/mbox_irq_flag.sv
module mbox_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_n_o
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set_i || clr_i;
    flag_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign irq_n_o = !flag_q;

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> !irq_n_o);

  // R3
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> irq_n_o);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(irq_n_o));
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
  import mbox_pkg::*;
#(
  parameter int AW        = 12,
  parameter int RST_STAGE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_en_n,
  input  logic          l_oe_n,
  input  logic          l_we_n,
  input  logic [AW-1:0] l_addr,
  input  logic          l_busy_n,
  output logic          l_irq_n,
  input  logic          r_en_n,
  input  logic          r_oe_n,
  input  logic          r_we_n,
  input  logic [AW-1:0] r_addr,
  input  logic          r_busy_n,
  output logic          r_irq_n
);
  localparam logic [AW-1:0] TOP_ADDR = '1;
  localparam logic [AW-1:0] BOX_L    = TOP_ADDR - AW'(1);
  localparam logic [AW-1:0] BOX_R    = TOP_ADDR;

  logic            rst_sync_n;
  port_ctl_t       ctl   [NPORT];
  logic [AW-1:0]   addr  [NPORT];
  logic [NPORT-1:0] wr_peer;
  logic [NPORT-1:0] rd_own;
  logic [NPORT-1:0] irq_n;

  mbox_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    ctl[LEFT]   = '{en_n: l_en_n, oe_n: l_oe_n, we_n: l_we_n, busy_n: l_busy_n};
    ctl[RIGHT]  = '{en_n: r_en_n, oe_n: r_oe_n, we_n: r_we_n, busy_n: r_busy_n};
    addr[LEFT]  = l_addr;
    addr[RIGHT] = r_addr;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam logic [AW-1:0] OWN  = (p == LEFT) ? BOX_L : BOX_R;
    localparam logic [AW-1:0] PEER = (p == LEFT) ? BOX_R : BOX_L;

    mbox_port_decode #(.AW(AW), .OWN_ADDR(OWN), .PEER_ADDR(PEER)) u_dec (
      .ctl_i     (ctl[p]),
      .addr_i    (addr[p]),
      .wr_peer_o (wr_peer[p]),
      .rd_own_o  (rd_own[p])
    );

    mbox_irq_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .set_i   (wr_peer[NPORT-1-p]),
      .clr_i   (rd_own[p]),
      .irq_n_o (irq_n[p])
    );
  end

  assign l_irq_n = irq_n[LEFT];
  assign r_irq_n = irq_n[RIGHT];

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (l_irq_n && r_irq_n));

  // R6
  l_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(l_irq_n) |-> $past(!r_en_n && !r_we_n && r_addr == BOX_L && r_busy_n));

  // R6
  r_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(r_irq_n) |-> $past(!l_en_n && !l_we_n && l_addr == BOX_R && l_busy_n));
endmodule

// File: tb/mbox_irq_ctrl_test.sv
module mbox_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam logic [AW-1:0] MB_L = 12'hFFE;
  localparam logic [AW-1:0] MB_R = 12'hFFF;

  logic clk = 1'b0;
  logic rst_n;
  logic l_en_n, l_oe_n, l_we_n, l_busy_n;
  logic r_en_n, r_oe_n, r_we_n, r_busy_n;
  logic [AW-1:0] l_addr, r_addr;
  logic l_irq_n, r_irq_n;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string cur_req = "R1";
  bit m_l, m_r, model_ok = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_irq_ctrl #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .l_en_n(l_en_n), .l_oe_n(l_oe_n), .l_we_n(l_we_n), .l_addr(l_addr),
    .l_busy_n(l_busy_n), .l_irq_n(l_irq_n),
    .r_en_n(r_en_n), .r_oe_n(r_oe_n), .r_we_n(r_we_n), .r_addr(r_addr),
    .r_busy_n(r_busy_n), .r_irq_n(r_irq_n)
  );

  // behavioural reference: a flag is a pending message bit per side
  always @(posedge clk) begin
    bit set_l, set_r, clr_l, clr_r;
    if (!rst_n) begin
      m_l = 0; m_r = 0; model_ok = 1'b1;
    end else begin
      set_l = (r_en_n === 0) && (r_we_n === 0) && (r_addr === MB_L) && (r_busy_n === 1);
      set_r = (l_en_n === 0) && (l_we_n === 0) && (l_addr === MB_R) && (l_busy_n === 1);
      clr_l = (l_en_n === 0) && (l_oe_n === 0) && (l_addr === MB_L);
      clr_r = (r_en_n === 0) && (r_oe_n === 0) && (r_addr === MB_R);
      if (clr_l) m_l = 0;
      if (set_l) m_l = 1;
      if (clr_r) m_r = 0;
      if (set_r) m_r = 1;
    end
  end

  task automatic chk(input string req, input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, got, exp);
    end
  endtask

  // compare every clock, a quarter period after the edge
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    cycles++;
    if (model_ok) begin
      chk(cur_req, l_irq_n, !m_l, "per-cycle l_irq_n");
      chk(cur_req, r_irq_n, !m_r, "per-cycle r_irq_n");
    end
  end

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  task automatic idle;
    l_en_n = 1; l_oe_n = 1; l_we_n = 1; l_addr = '0; l_busy_n = 1;
    r_en_n = 1; r_oe_n = 1; r_we_n = 1; r_addr = '0; r_busy_n = 1;
  endtask

  task automatic drv_l(input logic en, oe, we, input logic [AW-1:0] a, input logic bz);
    l_en_n = en; l_oe_n = oe; l_we_n = we; l_addr = a; l_busy_n = bz;
  endtask

  task automatic drv_r(input logic en, oe, we, input logic [AW-1:0] a, input logic bz);
    r_en_n = en; r_oe_n = oe; r_we_n = we; r_addr = a; r_busy_n = bz;
  endtask

  // apply driven values for one edge, then return to idle at the negedge
  task automatic tick;
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1", l_irq_n, 1'b1, "l_irq_n in reset");
    chk("R1", r_irq_n, 1'b1, "r_irq_n in reset");
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1", l_irq_n, 1'b1, "l_irq_n after reset");
    chk("R1", r_irq_n, 1'b1, "r_irq_n after reset");

    // R2: right writes left mailbox
    cur_req = "R2";
    drv_r(0, 1, 0, MB_L, 1); tick();
    chk("R2", l_irq_n, 1'b0, "left raised by right write");
    chk("R2", r_irq_n, 1'b1, "right untouched");

    // R8: non-clearing accesses
    cur_req = "R8";
    drv_l(0, 1, 1, MB_L, 1); tick();
    chk("R8", l_irq_n, 1'b0, "owner access with oe_n high");
    drv_l(1, 0, 1, MB_L, 1); tick();
    chk("R8", l_irq_n, 1'b0, "owner access with en_n high");
    drv_l(0, 0, 1, 12'h123, 1); drv_r(0, 0, 0, 12'h7FE, 1); tick();
    chk("R8", l_irq_n, 1'b0, "other addresses");
    chk("R8", r_irq_n, 1'b1, "other addresses right");
    drv_r(0, 0, 1, MB_L, 1); drv_l(0, 1, 1, MB_R, 1); tick();
    chk("R8", l_irq_n, 1'b0, "non-owner mailbox reads");
    chk("R8", r_irq_n, 1'b1, "non-owner mailbox reads right");
    drv_l(0, 1, 0, MB_L, 1); tick();
    chk("R8", l_irq_n, 1'b0, "owner writes own box oe_n high");

    // R3: clear with we_n low, then with we_n high
    cur_req = "R3";
    drv_l(0, 0, 0, MB_L, 1); tick();
    chk("R3", l_irq_n, 1'b1, "clear with we_n low");
    drv_r(0, 1, 0, MB_L, 1); tick();
    chk("R2", l_irq_n, 1'b0, "re-raise");
    drv_l(0, 0, 1, MB_L, 1); tick();
    chk("R3", l_irq_n, 1'b1, "clear with we_n high");

    // R4 / R5
    cur_req = "R4";
    drv_l(0, 1, 0, MB_R, 1); tick();
    chk("R4", r_irq_n, 1'b0, "right raised by left write");
    chk("R4", l_irq_n, 1'b1, "left untouched");
    cur_req = "R5";
    drv_r(0, 0, 0, MB_R, 1); tick();
    chk("R5", r_irq_n, 1'b1, "right cleared");

    // R6: busy blocks set
    cur_req = "R6";
    drv_r(0, 1, 0, MB_L, 0); tick();
    chk("R6", l_irq_n, 1'b1, "blocked right write");
    drv_l(0, 1, 0, MB_R, 0); tick();
    chk("R6", r_irq_n, 1'b1, "blocked left write");
    drv_l(0, 1, 0, MB_R, 1); drv_r(0, 1, 0, MB_L, 0); tick();
    chk("R6", l_irq_n, 1'b1, "blocked right write beside good left");
    chk("R4", r_irq_n, 1'b0, "good left write beside blocked");
    drv_r(0, 0, 1, MB_R, 1); tick();

    // R7: set and clear on the same edge
    cur_req = "R7";
    drv_r(0, 1, 0, MB_L, 1); drv_l(0, 0, 1, MB_L, 1); tick();
    chk("R7", l_irq_n, 1'b0, "set wins from clear state");
    drv_r(0, 1, 0, MB_L, 1); drv_l(0, 0, 1, MB_L, 1); tick();
    chk("R7", l_irq_n, 1'b0, "set wins from set state");
    drv_l(0, 0, 0, MB_R, 1); drv_r(0, 0, 1, MB_R, 1); tick();
    chk("R7", r_irq_n, 1'b0, "set wins on right");

    // R9: independence
    cur_req = "R9";
    drv_l(0, 0, 1, MB_L, 1); tick();
    chk("R9", l_irq_n, 1'b1, "left cleared");
    chk("R9", r_irq_n, 1'b0, "right still set");
    drv_l(0, 1, 0, MB_R, 1); drv_r(0, 1, 0, MB_L, 1); tick();
    chk("R9", l_irq_n, 1'b0, "both set left");
    chk("R9", r_irq_n, 1'b0, "both set right");
    drv_r(0, 0, 1, MB_R, 1); tick();
    chk("R9", r_irq_n, 1'b1, "right cleared alone");
    chk("R9", l_irq_n, 1'b0, "left kept");

    // R1: reset mid-run returns both inactive
    cur_req = "R1";
    drv_l(0, 1, 0, MB_R, 1); tick();
    rst_n = 0;
    @(negedge clk);
    chk("R1", l_irq_n, 1'b1, "l_irq_n after mid-run reset");
    chk("R1", r_irq_n, 1'b1, "r_irq_n after mid-run reset");
    rst_n = 1;
    repeat (4) @(negedge clk);
    summary();
  end
endmodule